// File: doc/BRIEF.md
# Request Notification Broadcast Mesh

This block is a small two-dimensional mesh of notification nodes that runs beside a main packet network. When a tile's core has just injected a coherence request on the main network, the tile raises a one-bit announcement. The announcement carries no address and no data. It only states that the tile requested.

Every node ORs the vectors it receives from its north, south, east and west neighbours into its own accumulator, together with its local announcement. It forwards the result one hop per clock cycle. There are no buffers and no backpressure, so the traversal time is fixed and known. A shared window timer splits time into windows of `WIN` cycles, and `WIN` covers the worst-case hop count across the mesh. When a window closes, every tile emits the same vector of requesters in the same cycle. This lets the coherence layer treat that vector as a globally agreed ordering snapshot.

A tile may announce only in the first cycle of a window. An announcement in any other cycle is dropped, which guarantees that it reaches every tile before the window closes. The snapshot of window k is presented in the first cycle of window k+1, and that is the same cycle in which new announcements for window k+1 are taken.

Top module: `notice_mesh`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `win_start_o` is 1 and every bit of `snap_valid_o` is 0.
- R2: `win_start_o` is high for exactly one cycle in every `WIN` cycles. The first window starts in the first cycle after reset release.
- R3: A bit of `req_i` is taken only in a cycle where `win_start_o` is 1. In any other cycle it is ignored and appears in no snapshot.
- R4: Each bit of `snap_valid_o` pulses high for exactly one cycle at the start of every window after the first. That cycle coincides with `win_start_o`, so the first pulse comes `WIN` cycles after reset release.
- R5: During that pulse, bit t of a tile's snapshot is 1 exactly when tile t announced at the start of the window just closed. Tile t sits at row t/COLS and column t%COLS.
- R6: All tiles pulse valid in the same cycle with identical snapshot vectors. Tile i's snapshot occupies `snap_vec_o[i*TILES +: TILES]`.
- R7: With the minimum window length (hop diameter plus one), announcements from opposite corners still reach every tile within the window.
- R8: The accumulators are cleared at each window boundary. An announcement from one window never appears in a later window's snapshot.
- R9: An announcement made in the cycle where the previous snapshot is delivered goes only into the next snapshot.
- R10: Between pulses, each tile's snapshot output holds the last delivered vector. After reset and before the first pulse it holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | TILES | Per-tile announcement; bit t belongs to tile t |
| win_start_o | output | 1 | High in the first cycle of each window |
| snap_valid_o | output | TILES | Per-tile one-cycle snapshot valid pulse |
| snap_vec_o | output | TILES*TILES | Per-tile snapshot vectors, tile i at bits i*TILES +: TILES |

## Verification
Two events meet in the first cycle of a window: the delivery of the previous window's snapshot, and the intake of new announcements. The bench provokes this by running windows back to back with different announcement patterns. In that shared cycle it checks the delivered vector against the previous pattern only, while it drives the next pattern. A following window then confirms that the new pattern shows up alone. Late announcements driven in every non-start cycle check that the intake gate does not leak into either snapshot.

// File: rtl/notice_pkg.sv
package notice_pkg;
   localparam int NB_PORTS = 4;

   typedef enum int {
      NB_NORTH = 0,
      NB_SOUTH = 1,
      NB_EAST  = 2,
      NB_WEST  = 3
   } nb_port_e;

   // worst-case hop count between two tiles of a rows x cols mesh
   function automatic int mesh_diam(input int rows, input int cols);
      return (rows - 1) + (cols - 1);
   endfunction
endpackage

// File: rtl/notice_window_timer.sv
module notice_window_timer #(
   parameter int WIN = 11
) (
   input  logic clk,
   input  logic rst_n,
   output logic phase0_o,
   output logic close_o
);
   localparam int CW = (WIN > 1) ? $clog2(WIN) : 1;
   localparam logic [CW-1:0] LAST = CW'(WIN - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= '0;
      else if (cnt_q == LAST)  cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
   end

   assign phase0_o = (cnt_q == '0);
   assign close_o  = (cnt_q == LAST);

   // R2: a closing cycle is always followed by a window start
   assert_close_then_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      close_o |=> phase0_o);

   // R2: a start never lasts longer than one cycle
   assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      phase0_o |=> !phase0_o);
endmodule

// File: rtl/notice_merge.sv
module notice_merge #(
   parameter int W   = 36,
   parameter int NIN = 6
) (
   input  logic [NIN-1:0][W-1:0] in_i,
   output logic [W-1:0]          out_o
);
   logic [W-1:0] pre [NIN];

   assign pre[0] = in_i[0];

   for (genvar k = 1; k < NIN; k++) begin : g_chain
      assign pre[k] = pre[k-1] | in_i[k];
   end

   assign out_o = pre[NIN-1];
endmodule

// File: rtl/notice_node.sv
module notice_node
   import notice_pkg::*;
#(
   parameter int TILES   = 36,
   parameter int TILE_ID = 0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          phase0_i,
   input  logic                          close_i,
   input  logic                          req_i,
   input  logic [NB_PORTS-1:0][TILES-1:0] nb_i,
   output logic [TILES-1:0]              acc_o,
   output logic                          snap_valid_o,
   output logic [TILES-1:0]              snap_o
);
   localparam int NIN = NB_PORTS + 2;

   logic [TILES-1:0]          acc_q, snap_q, inj, merged;
   logic                      valid_q;
   logic [NIN-1:0][TILES-1:0] srcs;

   // local announcement is gated to the first cycle of the window
   always_comb begin
      inj          = '0;
      inj[TILE_ID] = req_i & phase0_i;
   end

   assign srcs = {inj, nb_i, acc_q};

   notice_merge #(.W(TILES), .NIN(NIN)) i_merge (
      .in_i  (srcs),
      .out_o (merged)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q   <= '0;
         snap_q  <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= close_i;
         if (close_i) begin
            snap_q <= merged;
            acc_q  <= '0;
         end else begin
            acc_q  <= merged;
         end
      end
   end

   assign acc_o        = acc_q;
   assign snap_valid_o = valid_q;
   assign snap_o       = snap_q;

   // R4: the valid pulse lasts one cycle
   assert_valid_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      snap_valid_o |=> !snap_valid_o);

   // R4: the pulse coincides with a window start
   assert_valid_at_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      snap_valid_o |-> phase0_i);

   // R8: every window begins with an empty accumulator
   assert_clear_at_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      phase0_i |-> (acc_q == '0));

   // R10: the snapshot only changes together with a valid pulse
   assert_snap_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !snap_valid_o |-> $stable(snap_o));
endmodule

// File: rtl/notice_mesh.sv
module notice_mesh
   import notice_pkg::*;
#(
   parameter int ROWS  = 6,
   parameter int COLS  = 6,
   parameter int TILES = ROWS * COLS,
   parameter int WIN   = mesh_diam(ROWS, COLS) + 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [TILES-1:0]         req_i,
   output logic                     win_start_o,
   output logic [TILES-1:0]         snap_valid_o,
   output logic [TILES*TILES-1:0]   snap_vec_o
);
   localparam int DIAM    = mesh_diam(ROWS, COLS);
   localparam int MIN_WIN = DIAM + 1;

   if (ROWS < 1 || COLS < 1) begin : g_bad_dims
      initial $fatal(1, "notice_mesh: ROWS and COLS must be at least 1");
   end
   if (TILES != ROWS * COLS) begin : g_bad_tiles
      initial $fatal(1, "notice_mesh: TILES must equal ROWS*COLS");
   end
   if (WIN < MIN_WIN || WIN < 2) begin : g_bad_win
      initial $fatal(1, "notice_mesh: WIN must cover the hop diameter plus one");
   end

   logic phase0, close_w;
   logic [TILES-1:0] acc_w [TILES];

   notice_window_timer #(.WIN(WIN)) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .phase0_o (phase0),
      .close_o  (close_w)
   );

   assign win_start_o = phase0;

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      for (genvar c = 0; c < COLS; c++) begin : g_col
         localparam int ID = r * COLS + c;
         logic [NB_PORTS-1:0][TILES-1:0] nb;

         if (r > 0) begin : g_n
            assign nb[NB_NORTH] = acc_w[ID - COLS];
         end else begin : g_n_edge
            assign nb[NB_NORTH] = '0;
         end
         if (r < ROWS - 1) begin : g_s
            assign nb[NB_SOUTH] = acc_w[ID + COLS];
         end else begin : g_s_edge
            assign nb[NB_SOUTH] = '0;
         end
         if (c < COLS - 1) begin : g_e
            assign nb[NB_EAST] = acc_w[ID + 1];
         end else begin : g_e_edge
            assign nb[NB_EAST] = '0;
         end
         if (c > 0) begin : g_w
            assign nb[NB_WEST] = acc_w[ID - 1];
         end else begin : g_w_edge
            assign nb[NB_WEST] = '0;
         end

         notice_node #(.TILES(TILES), .TILE_ID(ID)) i_node (
            .clk          (clk),
            .rst_n        (rst_n),
            .phase0_i     (phase0),
            .close_i      (close_w),
            .req_i        (req_i[ID]),
            .nb_i         (nb),
            .acc_o        (acc_w[ID]),
            .snap_valid_o (snap_valid_o[ID]),
            .snap_o       (snap_vec_o[ID*TILES +: TILES])
         );

         // R6: every tile agrees with tile 0 on timing and content
         assert_tiles_agree_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (snap_valid_o[ID] == snap_valid_o[0]) &&
            (snap_vec_o[ID*TILES +: TILES] == snap_vec_o[TILES-1:0]));
      end
   end

   // R4: a snapshot is delivered only when a window begins
   assert_pulse_on_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      snap_valid_o[0] |-> win_start_o);
endmodule

// File: tb/test_notice_mesh.sv
`timescale 1ns/1ps
module test_notice_mesh;
   localparam int ROWS  = 6;
   localparam int COLS  = 6;
   localparam int TILES = ROWS * COLS;
   localparam int WIN   = ROWS + COLS - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [TILES-1:0] req = '0;
   logic win_start;
   logic [TILES-1:0] snap_valid;
   logic [TILES*TILES-1:0] snap_vec;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;
   logic [TILES-1:0] prev_exp = '0;

   always #2.5 clk = ~clk;

   notice_mesh #(.ROWS(ROWS), .COLS(COLS), .WIN(WIN)) i_notice_mesh (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_i        (req),
      .win_start_o  (win_start),
      .snap_valid_o (snap_valid),
      .snap_vec_o   (snap_vec)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [TILES-1:0] act, input logic [TILES-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // Entered at the sampling point of a window's first cycle. Drives inj there,
   // drives noise in every later cycle, then checks the delivered snapshot.
   task automatic run_window(input logic [TILES-1:0] inj, input logic [TILES-1:0] noise,
                             input string tag);
      bit low_ok = 1'b1, hold_ok = 1'b1, ws_ok = 1'b1, agree_ok = 1'b1;
      logic [TILES-1:0] bad_vec = '0;
      logic [TILES-1:0] held_bad = '0;
      req = inj;
      for (int k = 1; k < WIN; k++) begin
         @(negedge clk);
         req = noise;
         if (snap_valid != '0) low_ok = 1'b0;
         if (win_start) ws_ok = 1'b0;
         for (int t = 0; t < TILES; t++)
            if (snap_vec[t*TILES +: TILES] != prev_exp) begin
               hold_ok  = 1'b0;
               held_bad = snap_vec[t*TILES +: TILES];
            end
      end
      @(negedge clk);
      req = '0;
      check(low_ok, "R4", {tag, " valid low inside window"}, TILES'(snap_valid), '0);
      check(ws_ok, "R2", {tag, " no start inside window"}, TILES'(win_start), '0);
      check(hold_ok, "R10", {tag, " snapshot held between pulses"}, held_bad, prev_exp);
      check(win_start == 1'b1, "R2", {tag, " start after WIN cycles"}, TILES'(win_start), TILES'(1));
      check(snap_valid == '1, "R4", {tag, " valid pulse on all tiles"}, snap_valid, '1);
      check(snap_vec[TILES-1:0] == inj, tag, "tile 0 snapshot content", snap_vec[TILES-1:0], inj);
      for (int t = 1; t < TILES; t++)
         if (snap_vec[t*TILES +: TILES] != inj) begin
            agree_ok = 1'b0;
            bad_vec  = snap_vec[t*TILES +: TILES];
         end
      check(agree_ok, "R6", {tag, " all tiles identical"}, bad_vec, inj);
      prev_exp = inj;
   endtask

   task automatic test_reset_r1();
      repeat (3) @(negedge clk);
      check(snap_valid == '0, "R1", "valid low in reset", snap_valid, '0);
      check(win_start == 1'b1, "R1", "start high in reset", TILES'(win_start), TILES'(1));
      rst_n = 1'b1;
      check(snap_valid == '0, "R1", "valid low after release", snap_valid, '0);
      check(snap_vec == '0, "R10", "snapshot zero after reset", snap_vec[TILES-1:0], '0);
   endtask

   task automatic test_single_r5();
      run_window(TILES'(1) << 7, '0, "R5");
   endtask

   task automatic test_corners_r7();
      logic [TILES-1:0] v = '0;
      v[0] = 1'b1;
      v[TILES-1] = 1'b1;
      run_window(v, '0, "R7");
   endtask

   task automatic test_late_ignored_r3();
      run_window('0, '1, "R3");
      run_window(TILES'(1) << 3, ~(TILES'(1) << 3), "R3");
   endtask

   task automatic test_clear_r8();
      run_window('1, '0, "R5");
      run_window('0, '0, "R8");
   endtask

   task automatic test_back_to_back_r9();
      logic [TILES-1:0] a = '0, b = '0;
      for (int t = 0; t < TILES; t++) begin
         a[t] = ((t / COLS + t % COLS) % 2) == 0;
         b[t] = !a[t];
      end
      run_window(a, '0, "R9");
      run_window(b, '0, "R9");
      run_window(TILES'(1) << (TILES - COLS), '0, "R9");
   endtask

   initial begin
      test_reset_r1();
      test_single_r5();
      test_corners_r7();
      test_late_ignored_r3();
      test_clear_r8();
      test_back_to_back_r9();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R4 watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule